// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block is the host side of a byte-wide parallel printer port. A small I/O bus with a 2-bit offset reaches three registers. The data register holds the byte driven onto the eight data lines. The status register is read-only and shows the printer's feedback lines together with the live interrupt flag. The control register drives the four connector control lines and also holds an interrupt enable and a data direction bit.

Some control bits reach the connector inverted and one reaches it with true polarity. The printer feedback lines are re-timed into the clock domain before any logic uses them, and so are the data lines read back when the port is turned around. A falling edge on the acknowledge line, with interrupts enabled, latches a pending interrupt. Software reads the status register to take that interrupt.

Top module: `lpt_host_port`

## Requirements
- R1: After reset the data and control registers are 0, so pin_strobe=1, pin_autofeed=1, pin_init=0, pin_selin=1, pd_oe=1, irq=0, and rdata=0.
- R2: With control bit 5 clear, a write to offset 0 loads the data register. pd_o shows the value from the next cycle, and a read of offset 0 returns it.
- R3: A write to offset 2 stores control bits 5:0. A read of offset 2 returns those bits, with bits 7:6 always 0.
- R4: Control bits 0, 1 and 3 drive pin_strobe, pin_autofeed and pin_selin inverted. Control bit 2 drives pin_init with true polarity. Control bit 4 (interrupt enable) drives no pin.
- R5: With control bit 5 set, pd_oe is 0 and a read of offset 0 returns pd_i as re-timed through two flops. The data register keeps its value, and pd_o shows it again once bit 5 is cleared.
- R6: A read of offset 1 returns {~busy, ack, paper_out, select, fault, irq pending, 1, 1}, bit 7 first. The feedback inputs are seen after two clock re-timing stages.
- R7: irq is set by a falling edge of the re-timed pin_ack while control bit 4 is 1. With bit 4 at 0, an ack edge leaves irq unchanged.
- R8: A status read returns irq pending as it was before the read and clears irq. An ack falling edge taken in the same cycle as that read keeps irq set.
- R9: Writes to offsets 1 and 3 change no register. A read of offset 3 returns 0.
- R10: rdata is registered. It takes the addressed value in the cycle after rd_en and holds it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pd_o | output | 8 | Data lines, driven value |
| pd_oe | output | 1 | Data line output enable |
| pd_i | input | 8 | Data lines, received value |
| pin_strobe | output | 1 | Strobe line |
| pin_autofeed | output | 1 | Auto line-feed line |
| pin_init | output | 1 | Printer initialise line |
| pin_selin | output | 1 | Select-input line |
| pin_busy | input | 1 | Printer busy |
| pin_ack | input | 1 | Printer acknowledge |
| pin_paper_out | input | 1 | Paper empty |
| pin_select | input | 1 | Printer selected |
| pin_fault | input | 1 | Printer error |
| irq | output | 1 | Pending interrupt |

## Verification
The assertions assume that wr_en and rd_en are never both high in one cycle. They also assume that the printer lines and pd_i are asynchronous levels, which is why every check on them is taken only after the re-timing stages. The bench keeps to these rules. It issues one bus operation at a time, and it changes the feedback and data pins only inside a dedicated step that then waits four cycles before the next access. In the one directed case, an ack edge is placed so that the clearing read lands on the same clock edge as the set.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int DW       = 8;
    localparam int AW       = 2;
    localparam int CTRL_W   = 6;
    localparam int FB_W     = 5;

    localparam logic [AW-1:0] OFS_DATA   = 2'd0;
    localparam logic [AW-1:0] OFS_STATUS = 2'd1;
    localparam logic [AW-1:0] OFS_CTRL   = 2'd2;

    localparam int CB_STROBE = 0;
    localparam int CB_AUTOFD = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_SELIN  = 3;
    localparam int CB_IEN    = 4;
    localparam int CB_DIR    = 5;

    typedef struct packed {
        logic [DW-1:0]     data;
        logic [CTRL_W-1:0] ctrl;
        logic [DW-1:0]     rdata;
    } host_regs_t;

    typedef struct packed {
        logic ack_prev;
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_pin_drive.sv
module lpt_pin_drive
    import lpt_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output logic              strobe,
    output logic              autofeed,
    output logic              init,
    output logic              selin,
    output logic              oe
);
    // Inverted lines: strobe, auto-feed, select-in. Init is true polarity.
    always_comb begin
        strobe   = ~ctrl[CB_STROBE];
        autofeed = ~ctrl[CB_AUTOFD];
        init     =  ctrl[CB_INIT];
        selin    = ~ctrl[CB_SELIN];
        oe       = ~ctrl[CB_DIR];
    end
endmodule

// File: rtl/lpt_status_unit.sv
module lpt_status_unit
    import lpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          ack,
    input  logic          paper_out,
    input  logic          select,
    input  logic          fault,
    input  logic          ien,
    input  logic          rd_clr,
    output logic [DW-1:0] status,
    output logic          irq
);
    logic [FB_W-1:0] fb_s;
    logic            ack_fall;
    irq_state_t      st_d, st_q;

    lpt_sync #(.W(FB_W), .STAGES(SYNC_STAGES)) u_fb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({busy, ack, paper_out, select, fault}),
        .q     (fb_s)
    );

    assign ack_fall = st_q.ack_prev & ~fb_s[3];

    always_comb begin
        st_d          = st_q;
        st_d.ack_prev = fb_s[3];
        st_d.irq      = (ien & ack_fall) | (st_q.irq & ~rd_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = {~fb_s[4], fb_s[3], fb_s[2], fb_s[1], fb_s[0], st_q.irq, 2'b11};
    assign irq    = st_q.irq;

    p_irq_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(ien));
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !(ien && ack_fall)) |=> !st_q.irq);
    p_irq_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ien && ack_fall) |=> st_q.irq);
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !rd_clr) |=> st_q.irq);
endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
    import lpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] pd_o,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_i,
    output logic          pin_strobe,
    output logic          pin_autofeed,
    output logic          pin_init,
    output logic          pin_selin,
    input  logic          pin_busy,
    input  logic          pin_ack,
    input  logic          pin_paper_out,
    input  logic          pin_select,
    input  logic          pin_fault,
    output logic          irq
);
    host_regs_t    r_d, r_q;
    logic [DW-1:0] pd_s;
    logic [DW-1:0] status_byte;
    logic          rd_clr;

    assign rd_clr = rd_en && (addr == OFS_STATUS);

    lpt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_i),
        .q     (pd_s)
    );

    lpt_status_unit #(.SYNC_STAGES(SYNC_STAGES)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (pin_busy),
        .ack       (pin_ack),
        .paper_out (pin_paper_out),
        .select    (pin_select),
        .fault     (pin_fault),
        .ien       (r_q.ctrl[CB_IEN]),
        .rd_clr    (rd_clr),
        .status    (status_byte),
        .irq       (irq)
    );

    lpt_pin_drive u_pins (
        .ctrl     (r_q.ctrl),
        .strobe   (pin_strobe),
        .autofeed (pin_autofeed),
        .init     (pin_init),
        .selin    (pin_selin),
        .oe       (pd_oe)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == OFS_DATA) r_d.data = wdata;
            if (addr == OFS_CTRL) r_d.ctrl = wdata[CTRL_W-1:0];
        end
        if (rd_en) begin
            unique case (addr)
                OFS_DATA:   r_d.rdata = r_q.ctrl[CB_DIR] ? pd_s : r_q.data;
                OFS_STATUS: r_d.rdata = status_byte;
                OFS_CTRL:   r_d.rdata = DW'(r_q.ctrl);
                default:    r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign pd_o  = r_q.data;

    p_pin_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL) |=>
            (pin_strobe == !$past(wdata[0])) && (pin_autofeed == !$past(wdata[1]))
            && (pin_init == $past(wdata[2])) && (pin_selin == !$past(wdata[3])));
    p_dir_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL) |=> (pd_oe == !$past(wdata[5])));
    p_ctrl_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CTRL) |=> (rdata[7:6] == 2'b00));
    p_status_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_STATUS) |=> (rdata[1:0] == 2'b11));
    p_ignored_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_STATUS || addr == 2'd3)) |=> ($stable(pd_o) && $stable(pd_oe) && $stable(pin_strobe)));
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DATA) |=> (pd_o == $past(wdata)));
endmodule

// File: tb/lpt_host_port_bench.sv
module lpt_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata, pd_o, pd_i = '0;
    logic       pd_oe, pin_strobe, pin_autofeed, pin_init, pin_selin, irq;
    logic       pin_busy = 1'b0, pin_ack = 1'b1, pin_paper_out = 1'b0, pin_select = 1'b0, pin_fault = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_data = '0;
    logic [5:0] m_ctrl = '0;
    logic       m_irq = 1'b0;
    bit         done = 0;

    always #2 clk = ~clk;

    lpt_host_port u_lpt_host_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pd_o(pd_o), .pd_oe(pd_oe), .pd_i(pd_i),
        .pin_strobe(pin_strobe), .pin_autofeed(pin_autofeed), .pin_init(pin_init),
        .pin_selin(pin_selin), .pin_busy(pin_busy), .pin_ack(pin_ack),
        .pin_paper_out(pin_paper_out), .pin_select(pin_select), .pin_fault(pin_fault),
        .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {~pin_busy, pin_ack, pin_paper_out, pin_select, pin_fault, m_irq, 2'b11};
    endfunction

    function automatic logic [4:0] exp_pins(input logic [5:0] c);
        return {~c[5], ~c[3], c[2], ~c[1], ~c[0]};
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        if (a == 2'd0) m_data = d;
        if (a == 2'd2) m_ctrl = d[5:0];
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_pins(input string req);
        check(req, {3'b0, pd_oe, pin_selin, pin_init, pin_autofeed, pin_strobe}, {3'b0, exp_pins(m_ctrl)});
    endtask

    task automatic set_inputs(input logic [4:0] fb, input logic [7:0] pdv);
        @(negedge clk);
        if (m_ctrl[4] && pin_ack && !fb[3]) m_irq = 1'b1;
        {pin_busy, pin_ack, pin_paper_out, pin_select, pin_fault} = fb;
        pd_i = pdv;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 pins", {3'b0, pd_oe, pin_selin, pin_init, pin_autofeed, pin_strobe}, 8'b0001_1011);
        check("R1 irq/rdata", {irq, rdata[6:0]}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 pd_o", pd_o, 8'h00);

        // R2 data write and read back
        bus_wr(2'd0, 8'hA5);
        check("R2 pd_o", pd_o, 8'hA5);
        bus_rd(2'd0, v); check("R2 readback", v, 8'hA5);
        // R10 rdata holds while idle
        repeat (3) @(negedge clk); check("R10 hold", rdata, 8'hA5);

        // R3 control upper bits read zero
        bus_wr(2'd2, 8'hCF);
        bus_rd(2'd2, v); check("R3 ctrl read", v, 8'h0F);
        check_pins("R4 polarity");

        // R9 writes to offsets 1 and 3 ignored, offset 3 reads 0
        bus_wr(2'd1, 8'hFF); bus_wr(2'd3, 8'h00);
        check("R9 pd_o kept", pd_o, 8'hA5);
        check_pins("R9 ctrl kept");
        bus_rd(2'd3, v); check("R9 offset3", v, 8'h00);

        // R5 direction turnaround
        bus_wr(2'd2, 8'h20);
        check("R5 oe off", {7'b0, pd_oe}, 8'h00);
        set_inputs({1'b0, 1'b1, 3'b000}, 8'h3C);
        bus_rd(2'd0, v); check("R5 read pins", v, 8'h3C);
        bus_wr(2'd0, 8'h77);
        bus_wr(2'd2, 8'h00);
        check("R5 latch kept", pd_o, 8'h77);
        bus_rd(2'd0, v); check("R5 read latch", v, 8'h77);

        // R7 ack edge without enable: no irq
        set_inputs(5'b01000, 8'h00);
        set_inputs(5'b00000, 8'h00);
        check("R7 no enable", {7'b0, irq}, 8'h00);
        // R7 with enable
        bus_wr(2'd2, 8'h10);
        set_inputs(5'b01000, 8'h00);
        set_inputs(5'b00000, 8'h00);
        check("R7 irq set", {7'b0, irq}, 8'h01);
        // R6/R8 status read shows then clears
        bus_rd(2'd1, v); check("R6 status", v, exp_status()); m_irq = 1'b0;
        check("R8 cleared", {7'b0, irq}, 8'h00);

        // R8 set wins over clear in same cycle
        set_inputs(5'b01000, 8'h00);
        bus_rd(2'd1, v);
        set_inputs(5'b01000, 8'h00);
        @(negedge clk); pin_ack = 1'b1;
        @(negedge clk); pin_ack = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 2'd1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R8 set wins", {7'b0, irq}, 8'h01);
        bus_rd(2'd1, v);
        check("R8 cleared again", {7'b0, irq}, 8'h00);
        m_irq = 1'b0;

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0: begin bus_wr(2'd0, 8'($urandom)); check("R2 rnd pd_o", pd_o, m_data); end
                1: begin bus_wr(2'd2, 8'($urandom)); check_pins("R4 rnd pins"); end
                2: begin
                    bus_rd(2'd0, v);
                    check("R5 rnd data read", v, m_ctrl[5] ? pd_i : m_data);
                end
                3: begin bus_rd(2'd2, v); check("R3 rnd ctrl", v, {2'b00, m_ctrl}); end
                4: begin
                    bus_rd(2'd1, v); check("R6 rnd status", v, exp_status());
                    m_irq = 1'b0;
                    check("R8 rnd clear", {7'b0, irq}, 8'h00);
                end
                5: begin
                    set_inputs(5'($urandom), 8'($urandom));
                    check("R7 rnd irq", {7'b0, irq}, {7'b0, m_irq});
                end
                default: begin
                    bus_wr($urandom_range(0, 1) ? 2'd1 : 2'd3, 8'($urandom));
                    check("R9 rnd ignore", pd_o, m_data);
                    check_pins("R9 rnd ctrl");
                end
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule